// File: doc/BRIEF.md
# Host Mailbox Command Responder

This block sits on the device side of a byte-wide host register window and acts on commands the host posts through a four-byte outgoing mailbox. The host first places a 16-bit parameter in the two low bytes. It then writes a command code into the third byte, and that write starts processing. After a fixed number of clock cycles the block acts on the command. Acting on it can mean latching an 8-bit output state, storing a configuration word (pulse-width high and low periods, burst counts, enable masks, pattern value, edge enables) or reading one of those values back. The block then publishes 16-bit feedback in the incoming mailbox and copies the command code into the incoming completion byte.

The host detects completion by polling the completion byte until it equals the code it sent. To issue the same command twice in a row, it first sends the clear command (code 0x00), which zeroes the completion byte so that the second completion can be seen. Codes the block does not recognise are dropped without any completion, so the host sees a timeout. A periodically resampled digital-input byte and a small interrupt enable/status register share the same address window.

Top module: `mbx_cmd_proc`

## Requirements
- R1: After reset the output state, feedback, completion byte, input status byte, interrupt enable, stored configuration words and all status flags are zero, and the irq output is low.
- R2: Command 0x01 copies parameter bits 7:0 to the output state and returns feedback {8'h00, parameter[7:0]}. The completion byte (address 6) becomes 0x01.
- R3: Command 0x02 returns feedback {8'h00, output state} and leaves the output state unchanged. The output state changes only through command 0x01.
- R4: A command accepted at a clock edge updates its results exactly LATENCY edges later. Until then the completion byte and the feedback keep their previous values.
- R5: Command 0x00 sets the completion byte and both feedback bytes to zero.
- R6: The configuration codes are 0x10 to 0x15 and 0x1F to 0x24. Each one stores its 16-bit parameter and returns that parameter as feedback. Command 0x03 returns the word last stored by the code held in parameter bits 7:0, or zero when that code is not a configuration code.
- R7: Any other command code changes no state: the completion byte, feedback, output state and configuration words all keep their values, and the completed flag stays clear.
- R8: A write to the command byte (address 2) while a command is pending is ignored.
- R9: The input status byte (address 7) samples the din input once every SAMPLE_CYCLES clock cycles, first at the SAMPLE_CYCLES-th edge after reset, and holds its value between samples.
- R10: Bit 5 of address 9 is a read/write interrupt enable. Address 10 is read-only, with these bits: bit 0 = command pending, bit 1 = command completed (set when a recognised command finishes, cleared when the next command is accepted), bit 6 = bit 0 OR bit 1, bit 7 = bit 6 AND enable. irq equals bit 7. Addresses 8 and 11 read zero.
- R11: Addresses 0 to 2 read back the parameter bytes and the last accepted command. Address 3 always reads zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Byte write strobe |
| host_addr | input | 4 | Byte address: 0-3 outgoing mailbox, 4-7 incoming mailbox, 8-11 interrupt register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| din | input | 8 | Isolated digital inputs |
| do_state | output | 8 | Latched output state |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted configuration word is silent until a 0x03 read names its code. The bench therefore stores words under several codes and reads each one back. A wrong latency count or a dropped pending flag shows up one edge early or late in the completion byte and in address 10. A reference model is compared every cycle while the read address rotates through all twelve bytes, so such faults appear in the first cycle they occur. A stuck sample counter shows up at address 7 within one sample period.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int NCFG  = 12;
    localparam int CFG_W = $clog2(NCFG);

    localparam logic [7:0] OP_CLEAR    = 8'h00;
    localparam logic [7:0] OP_SET_OUT  = 8'h01;
    localparam logic [7:0] OP_GET_OUT  = 8'h02;
    localparam logic [7:0] OP_READ_CFG = 8'h03;

    localparam logic [7:0] CFG_A_LO = 8'h10;
    localparam logic [7:0] CFG_A_HI = 8'h15;
    localparam logic [7:0] CFG_B_LO = 8'h1F;
    localparam logic [7:0] CFG_B_HI = 8'h24;
    localparam int         CFG_A_N  = 6;

    localparam logic [3:0] A_OB0  = 4'd0;
    localparam logic [3:0] A_OB1  = 4'd1;
    localparam logic [3:0] A_OB2  = 4'd2;
    localparam logic [3:0] A_OB3  = 4'd3;
    localparam logic [3:0] A_IB0  = 4'd4;
    localparam logic [3:0] A_IB1  = 4'd5;
    localparam logic [3:0] A_IB2  = 4'd6;
    localparam logic [3:0] A_IB3  = 4'd7;
    localparam logic [3:0] A_IRQ1 = 4'd9;
    localparam logic [3:0] A_IRQ2 = 4'd10;

    localparam int EN_BIT = 5;

    typedef enum logic [2:0] {
        K_NONE, K_CLEAR, K_SET_OUT, K_GET_OUT, K_READ_CFG, K_WRITE_CFG
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e        kind;
        logic [CFG_W-1:0] idx;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_op(input logic [7:0] code);
        cmd_dec_t d;
        d.kind = K_NONE;
        d.idx  = '0;
        case (code)
            OP_CLEAR:    d.kind = K_CLEAR;
            OP_SET_OUT:  d.kind = K_SET_OUT;
            OP_GET_OUT:  d.kind = K_GET_OUT;
            OP_READ_CFG: d.kind = K_READ_CFG;
            default: begin
                if (code >= CFG_A_LO && code <= CFG_A_HI) begin
                    d.kind = K_WRITE_CFG;
                    d.idx  = CFG_W'(code - CFG_A_LO);
                end else if (code >= CFG_B_LO && code <= CFG_B_HI) begin
                    d.kind = K_WRITE_CFG;
                    d.idx  = CFG_W'(code - CFG_B_LO + 8'(CFG_A_N));
                end
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input  logic [7:0] code,
    output cmd_dec_t   dec
);
    always_comb dec = decode_op(code);
endmodule

// File: rtl/mbx_cfg_regs.sv
module mbx_cfg_regs
    import mbx_pkg::*;
#(
    parameter int N = NCFG,
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [CFG_W-1:0] rd_idx,
    input  logic             rd_hit,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] words [N];

    for (genvar g = 0; g < N; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= '0;
            else if (wr_en && wr_idx == CFG_W'(g))
                words[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_hit && int'(rd_idx) < N)
            rd_data = words[rd_idx];
    end
endmodule

// File: rtl/mbx_din_sampler.sv
module mbx_din_sampler #(
    parameter int SAMPLE_CYCLES = 25000,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic         tick,
    output logic [W-1:0] status
);
    localparam int CW = $clog2(SAMPLE_CYCLES + 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(SAMPLE_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            status <= '0;
        end else if (tick) begin
            cnt    <= '0;
            status <= din;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mbx_cmd_proc.sv
module mbx_cmd_proc
    import mbx_pkg::*;
#(
    parameter int LATENCY       = 16,
    parameter int SAMPLE_CYCLES = 25000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic [3:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic [7:0] din,
    output logic [7:0] do_state,
    output logic       irq
);
    localparam int LW = $clog2(LATENCY + 1);

    logic [7:0]    ob0, ob1, cmd_q, echo_q, din_status;
    logic [15:0]   par_q, fb_q, cfg_rd;
    logic [LW-1:0] cnt;
    logic          busy, done_q, int_en, samp_tick, exec_now, accept;
    cmd_dec_t      op_dec, par_dec;

    mbx_decode u_op_dec  (.code(cmd_q),      .dec(op_dec));
    mbx_decode u_par_dec (.code(par_q[7:0]), .dec(par_dec));

    mbx_cfg_regs #(.N(NCFG), .W(16)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (exec_now && op_dec.kind == K_WRITE_CFG),
        .wr_idx  (op_dec.idx),
        .wr_data (par_q),
        .rd_idx  (par_dec.idx),
        .rd_hit  (par_dec.kind == K_WRITE_CFG),
        .rd_data (cfg_rd)
    );

    mbx_din_sampler #(.SAMPLE_CYCLES(SAMPLE_CYCLES), .W(8)) u_samp (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .tick   (samp_tick),
        .status (din_status)
    );

    assign accept   = host_wr && host_addr == A_OB2 && !busy;
    assign exec_now = busy && cnt == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ob0    <= '0;
            ob1    <= '0;
            int_en <= 1'b0;
        end else if (host_wr) begin
            case (host_addr)
                A_OB0:  ob0    <= host_wdata;
                A_OB1:  ob1    <= host_wdata;
                A_IRQ1: int_en <= host_wdata[EN_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            cmd_q    <= '0;
            par_q    <= '0;
            done_q   <= 1'b0;
            echo_q   <= '0;
            fb_q     <= '0;
            do_state <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            cnt    <= LW'(LATENCY - 1);
            cmd_q  <= host_wdata;
            par_q  <= {ob1, ob0};
            done_q <= 1'b0;
        end else if (exec_now) begin
            busy <= 1'b0;
            if (op_dec.kind != K_NONE) begin
                done_q <= 1'b1;
                echo_q <= cmd_q;
            end
            case (op_dec.kind)
                K_CLEAR: begin
                    echo_q <= '0;
                    fb_q   <= '0;
                end
                K_SET_OUT: begin
                    do_state <= par_q[7:0];
                    fb_q     <= {8'h00, par_q[7:0]};
                end
                K_GET_OUT:   fb_q <= {8'h00, do_state};
                K_READ_CFG:  fb_q <= cfg_rd;
                K_WRITE_CFG: fb_q <= par_q;
                default: ;
            endcase
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    logic pend_any;
    assign pend_any = busy || done_q;
    assign irq      = int_en && pend_any;

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_OB0:  host_rdata = ob0;
            A_OB1:  host_rdata = ob1;
            A_OB2:  host_rdata = cmd_q;
            A_IB0:  host_rdata = fb_q[7:0];
            A_IB1:  host_rdata = fb_q[15:8];
            A_IB2:  host_rdata = echo_q;
            A_IB3:  host_rdata = din_status;
            A_IRQ1: host_rdata = {2'b00, int_en, 5'b00000};
            A_IRQ2: host_rdata = {irq, pend_any, 4'b0000, done_q, busy};
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbx_cmd_proc_chk.sv
module mbx_cmd_proc_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_wr,
    input logic [3:0] host_addr,
    input logic [7:0] host_rdata,
    input logic [7:0] do_state,
    input logic       irq,
    input logic       busy,
    input logic       exec_now,
    input logic       exec_known,
    input logic       exec_set,
    input logic       exec_clr,
    input logic [7:0] par_lo,
    input logic [7:0] cmd_q,
    input logic [7:0] echo_q,
    input logic       int_en,
    input logic       samp_tick,
    input logic [7:0] din_status
);
    AST_SET_OUT_LATCH: assert property (@(posedge clk) disable iff (rst)
        exec_set |=> do_state == $past(par_lo)); // R2

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !exec_set |=> $stable(do_state)); // R3

    AST_ECHO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !exec_now) |=> $stable(echo_q)); // R4

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        exec_clr |=> echo_q == 8'h00); // R5

    AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (exec_now && !exec_known) |=> $stable(echo_q) && $stable(do_state)); // R7

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && host_wr && host_addr == 4'd2) |=> $stable(cmd_q)); // R8

    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !samp_tick |=> $stable(din_status)); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !int_en |-> !irq); // R10

    AST_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (rst)
        (!busy && host_wr && host_addr == 4'd2) |=> busy); // R10

    always_comb begin
        if (!rst && host_addr == 4'd3)
            AST_OB3_ZERO: assert (host_rdata == 8'h00); // R11
    end
endmodule

bind mbx_cmd_proc mbx_cmd_proc_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .do_state   (do_state),
    .irq        (irq),
    .busy       (busy),
    .exec_now   (exec_now),
    .exec_known (op_dec.kind != mbx_pkg::K_NONE),
    .exec_set   (exec_now && op_dec.kind == mbx_pkg::K_SET_OUT),
    .exec_clr   (exec_now && op_dec.kind == mbx_pkg::K_CLEAR),
    .par_lo     (par_q[7:0]),
    .cmd_q      (cmd_q),
    .echo_q     (echo_q),
    .int_en     (int_en),
    .samp_tick  (samp_tick),
    .din_status (din_status)
);

// File: tb/mbx_cmd_proc_tb_top.sv
`timescale 1ns/100ps
module mbx_cmd_proc_tb_top;
    localparam int LAT  = 5;
    localparam int SAMP = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [3:0] host_addr = 4'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic [7:0] din = 8'd0;
    logic [7:0] do_state;
    logic       irq;

    int    vectors = 0;
    int    fails   = 0;
    int    cycles  = 0;
    bit    ended   = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    mbx_cmd_proc #(.LATENCY(LAT), .SAMPLE_CYCLES(SAMP)) dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .din(din),
        .do_state(do_state), .irq(irq)
    );

    // behavioural reference model
    logic [7:0]  m_ob0, m_ob1, m_cmd, m_echo, m_do, m_din;
    logic [15:0] m_par, m_fb;
    logic        m_busy, m_done, m_en;
    int          m_cnt, m_scnt;
    int          m_cfg [int];

    function automatic bit is_cfg(int c);
        return (c >= 'h10 && c <= 'h15) || (c >= 'h1F && c <= 'h24);
    endfunction

    function automatic logic m_irq();
        return m_en && (m_busy || m_done);
    endfunction

    function automatic logic [7:0] m_rd(logic [3:0] a);
        case (a)
            4'd0: return m_ob0;
            4'd1: return m_ob1;
            4'd2: return m_cmd;
            4'd4: return m_fb[7:0];
            4'd5: return m_fb[15:8];
            4'd6: return m_echo;
            4'd7: return m_din;
            4'd9: return m_en ? 8'h20 : 8'h00;
            4'd10: return {m_irq(), m_busy || m_done, 4'b0, m_done, m_busy};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ob0 <= 0; m_ob1 <= 0; m_cmd <= 0; m_echo <= 0; m_do <= 0;
            m_din <= 0; m_par <= 0; m_fb <= 0; m_busy <= 0; m_done <= 0;
            m_en <= 0; m_cnt <= 0; m_scnt <= 0;
            m_cfg.delete();
        end else begin
            if (m_scnt == SAMP - 1) begin
                m_din  <= din;
                m_scnt <= 0;
            end else m_scnt <= m_scnt + 1;
            if (host_wr) begin
                if (host_addr == 0) m_ob0 <= host_wdata;
                if (host_addr == 1) m_ob1 <= host_wdata;
                if (host_addr == 9) m_en <= host_wdata[5];
                if (host_addr == 2 && !m_busy) begin
                    m_busy <= 1; m_cnt <= LAT - 1; m_cmd <= host_wdata;
                    m_par <= {m_ob1, m_ob0}; m_done <= 0;
                end
            end
            if (m_busy) begin
                if (m_cnt == 0) begin
                    m_busy <= 0;
                    if (m_cmd == 0) begin
                        m_echo <= 0; m_fb <= 0; m_done <= 1;
                    end else if (m_cmd == 1) begin
                        m_do <= m_par[7:0]; m_fb <= {8'h0, m_par[7:0]};
                        m_echo <= m_cmd; m_done <= 1;
                    end else if (m_cmd == 2) begin
                        m_fb <= {8'h0, m_do}; m_echo <= m_cmd; m_done <= 1;
                    end else if (m_cmd == 3) begin
                        if (is_cfg(int'(m_par[7:0])) && m_cfg.exists(int'(m_par[7:0])))
                            m_fb <= 16'(m_cfg[int'(m_par[7:0])]);
                        else m_fb <= 0;
                        m_echo <= m_cmd; m_done <= 1;
                    end else if (is_cfg(int'(m_cmd))) begin
                        m_cfg[int'(m_cmd)] = int'(m_par);
                        m_fb <= m_par; m_echo <= m_cmd; m_done <= 1;
                    end
                end else m_cnt <= m_cnt - 1;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !ended) begin
            vectors++;
            if (do_state !== m_do || irq !== m_irq() || host_rdata !== m_rd(host_addr)) begin
                fails++;
                $display("FAIL %s: do=%h exp %h irq=%b exp %b rd[%0d]=%h exp %h",
                         cur_req, do_state, m_do, irq, m_irq(), host_addr,
                         host_rdata, m_rd(host_addr));
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d exp below 100000", cycles);
            finish_run();
        end
    end

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            host_addr = 4'((int'(host_addr) + 1) % 12);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] v);
        host_addr = a; #0.5; v = host_rdata;
    endtask

    task automatic send(logic [7:0] code, logic [15:0] p);
        wr(0, p[7:0]); wr(1, p[15:8]); wr(2, code);
        idle(LAT + 1);
    endtask

    logic [7:0] v, v2;

    initial begin
        repeat (3) @(posedge clk);
        #1; rst = 0;
        cur_req = "R1";
        rd(6, v);  chk("R1", {8'h0, v}, 16'h0);
        rd(10, v); chk("R1", {8'h0, v}, 16'h0);
        chk("R1", {8'h0, do_state}, 16'h0);
        chk("R1", {15'h0, irq}, 16'h0);
        idle(2);

        cur_req = "R2";
        send(8'h01, 16'h77A5);
        chk("R2", {8'h0, do_state}, 16'h00A5);
        rd(4, v); rd(5, v2); chk("R2", {v2, v}, 16'h00A5);
        rd(6, v); chk("R2", {8'h0, v}, 16'h0001);

        cur_req = "R3";
        send(8'h02, 16'h1234);
        rd(4, v); rd(5, v2); chk("R3", {v2, v}, 16'h00A5);
        chk("R3", {8'h0, do_state}, 16'h00A5);

        cur_req = "R5";
        send(8'h00, 16'h0000);
        rd(6, v); chk("R5", {8'h0, v}, 16'h0);
        rd(4, v); rd(5, v2); chk("R5", {v2, v}, 16'h0);

        cur_req = "R4";
        wr(0, 8'h3C); wr(1, 8'h00); wr(2, 8'h01);
        idle(LAT - 1);
        rd(6, v); chk("R4", {8'h0, v}, 16'h0000);
        chk("R4", {8'h0, do_state}, 16'h00A5);
        idle(1);
        rd(6, v); chk("R4", {8'h0, v}, 16'h0001);
        chk("R4", {8'h0, do_state}, 16'h003C);
        idle(1);

        cur_req = "R6";
        send(8'h12, 16'h1234);
        rd(4, v); rd(5, v2); chk("R6", {v2, v}, 16'h1234);
        send(8'h21, 16'h00FF);
        send(8'h24, 16'hBEEF);
        send(8'h03, 16'h0012);
        rd(4, v); rd(5, v2); chk("R6", {v2, v}, 16'h1234);
        send(8'h03, 16'h0021);
        rd(4, v); rd(5, v2); chk("R6", {v2, v}, 16'h00FF);
        send(8'h03, 16'h0024);
        rd(4, v); rd(5, v2); chk("R6", {v2, v}, 16'hBEEF);
        send(8'h03, 16'h0030);
        rd(4, v); rd(5, v2); chk("R6", {v2, v}, 16'h0000);
        rd(6, v); chk("R6", {8'h0, v}, 16'h0003);

        cur_req = "R7";
        send(8'h77, 16'h5555);
        rd(6, v); chk("R7", {8'h0, v}, 16'h0003);
        rd(4, v); rd(5, v2); chk("R7", {v2, v}, 16'h0000);
        chk("R7", {8'h0, do_state}, 16'h003C);
        rd(10, v); chk("R7", {8'h0, v}, 16'h0000);
        send(8'h03, 16'h0012);
        rd(4, v); rd(5, v2); chk("R7", {v2, v}, 16'h1234);

        cur_req = "R8";
        wr(0, 8'h11); wr(1, 8'h00); wr(2, 8'h01);
        wr(2, 8'h02);
        rd(2, v); chk("R8", {8'h0, v}, 16'h0001);
        idle(LAT + 1);
        rd(6, v); chk("R8", {8'h0, v}, 16'h0001);
        chk("R8", {8'h0, do_state}, 16'h0011);
        idle(LAT + 2);
        rd(6, v); chk("R8", {8'h0, v}, 16'h0001);

        cur_req = "R9";
        din = 8'h5A;
        idle(SAMP + 1);
        rd(7, v); chk("R9", {8'h0, v}, 16'h005A);
        din = 8'hC3;
        idle(SAMP + 1);
        rd(7, v); chk("R9", {8'h0, v}, 16'h00C3);
        din = 8'h0F;
        idle(3 * SAMP);

        cur_req = "R10";
        wr(9, 8'h20);
        rd(9, v); chk("R10", {8'h0, v}, 16'h0020);
        rd(10, v); chk("R10", {8'h0, v}, 16'h00C2);
        wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h02);
        rd(10, v); chk("R10", {8'h0, v}, 16'h00C1);
        chk("R10", {15'h0, irq}, 16'h1);
        idle(LAT + 1);
        rd(10, v); chk("R10", {8'h0, v}, 16'h00C2);
        rd(8, v);  chk("R10", {8'h0, v}, 16'h0);
        rd(11, v); chk("R10", {8'h0, v}, 16'h0);
        wr(9, 8'hDF);
        rd(10, v); chk("R10", {8'h0, v}, 16'h0042);
        chk("R10", {15'h0, irq}, 16'h0);
        idle(2);

        cur_req = "R11";
        wr(3, 8'hFF);
        rd(3, v); chk("R11", {8'h0, v}, 16'h0);
        wr(0, 8'h9C); wr(1, 8'h4B);
        rd(0, v); rd(1, v2); chk("R11", {v2, v}, 16'h4B9C);
        idle(12);

        finish_run();
    end
endmodule